// File: doc/BRIEF.md
# 5B Code-Group Aligner and Decoder

This block sits in a 100 Mb/s receive path after the descrambler. It takes one received bit per clock, qualified by a valid strobe. It searches the bit stream for a start-of-stream delimiter, meaning the J code-group followed by the K code-group, with IDLE code-groups in front of it. When it finds one, it fixes the 5-bit code-group boundary at that point. It then translates every following code-group into a 4-bit nibble for a media-independent receive interface.

The delimiter itself is presented as two preamble nibbles. Each data nibble comes out with a one-cycle strobe, and receive-data-valid stays high for the whole frame. A frame ends on an end-of-stream pair (T then R) or on two IDLE code-groups in a row. After that the block drops data-valid and hunts for the next delimiter. A code-group that is not a known code inside a frame produces an error nibble, and decoding continues.

Top module: `cg_rx_decoder`

## Requirements
- R1: The first received bit is the MSB of each code-group. Once K has been taken in, each later run of five valid bits forms one code-group, counted from the bit after the last bit of K.
- R2: The pattern J (11000) then K (10001) starts a frame only when the PRE_IDLES code-groups just before J are all IDLE (11111). Any other J/K is ignored, and rx_dv stays 0 with no strobe.
- R3: At the start of a frame, rx_dv rises and nib_stb pulses with rx_nib = 0101 at the clock edge that takes in the last bit of K. A second strobe with rx_nib = 0101 follows on the next edge.
- R4: Data code-groups decode to nibbles as follows: 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F. Each decoded nibble gets one nib_stb pulse with rx_err = 0.
- R5: A T (01101) followed at once by R (00111) ends the frame: rx_dv falls at the edge that takes in the last bit of R. T and R are never strobed, and a T that is not followed by R is dropped.
- R6: Two consecutive IDLE code-groups end the frame in the same way. A single IDLE inside a frame is dropped without a strobe.
- R7: Any other code-group inside a frame produces one strobe with rx_err = 1 and rx_nib = ERR_NIB (default 1110). Decoding continues with the next code-group. rx_err is high only in such a strobe cycle.
- R8: Bits are taken only in cycles with bit_vld high. Gaps do not move the boundary. Every strobe other than the second preamble strobe follows a cycle with bit_vld high.
- R9: During and after reset, rx_dv, nib_stb and rx_err are 0, rx_nib is 0000, and the block hunts for a delimiter.
- R10: After a frame ends, a new idle-preceded J/K starts a new frame, whatever the bit phase of the stream before it.
- R11: nib_stb is high only while rx_dv is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Received descrambled bit |
| bit_vld | input | 1 | bit_in carries a new bit this cycle |
| rx_dv | output | 1 | Frame in progress |
| rx_nib | output | 4 | Decoded nibble |
| rx_err | output | 1 | Strobed nibble came from an invalid code-group |
| nib_stb | output | 1 | One-cycle strobe marking a new nibble |

## Verification
The bench uses the default values: PRE_IDLES = 1 and ERR_NIB = 1110. With a single IDLE prefix, a qualifying lead-in is only fifteen bits long. That keeps the following cases a few code-groups apart, so all of them fit in a short run:
- a J/K with a non-IDLE prefix;
- a delimiter at an arbitrary bit phase;
- both end conditions;
- an invalid code-group next to a lone IDLE and a lone T.

With the default error nibble, a miscoded group can be told apart from a decoded E only by rx_err. This makes the error flag itself the observable.

// File: rtl/cg_dec_pkg.sv
package cg_dec_pkg;
   localparam int GROUP_W = 5;
   localparam int NIB_W   = 4;

   localparam logic [GROUP_W-1:0] CG_J    = 5'b11000;
   localparam logic [GROUP_W-1:0] CG_K    = 5'b10001;
   localparam logic [GROUP_W-1:0] CG_T    = 5'b01101;
   localparam logic [GROUP_W-1:0] CG_R    = 5'b00111;
   localparam logic [GROUP_W-1:0] CG_IDLE = 5'b11111;
   localparam logic [NIB_W-1:0]   NIB_PRE = 4'b0101;

   typedef enum logic {ST_HUNT, ST_FRAME} dec_state_t;

   typedef struct packed {
      logic             is_data;
      logic [NIB_W-1:0] nib;
   } lut_out_t;

   function automatic lut_out_t cg_lookup(input logic [GROUP_W-1:0] cg);
      lut_out_t r;
      r.is_data = 1'b1;
      unique case (cg)
         5'b11110: r.nib = 4'h0;
         5'b01001: r.nib = 4'h1;
         5'b10100: r.nib = 4'h2;
         5'b10101: r.nib = 4'h3;
         5'b01010: r.nib = 4'h4;
         5'b01011: r.nib = 4'h5;
         5'b01110: r.nib = 4'h6;
         5'b01111: r.nib = 4'h7;
         5'b10010: r.nib = 4'h8;
         5'b10011: r.nib = 4'h9;
         5'b10110: r.nib = 4'hA;
         5'b10111: r.nib = 4'hB;
         5'b11010: r.nib = 4'hC;
         5'b11011: r.nib = 4'hD;
         5'b11100: r.nib = 4'hE;
         5'b11101: r.nib = 4'hF;
         default: begin
            r.is_data = 1'b0;
            r.nib     = 4'h0;
         end
      endcase
      return r;
   endfunction
endpackage

// File: rtl/cg_bit_window.sv
module cg_bit_window #(
   parameter int W = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_vld,
   input  logic         bit_in,
   output logic [W-1:0] win_nxt
);
   logic [W-1:0] win_q;

   assign win_nxt = {win_q[W-2:0], bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       win_q <= '0;
      else if (bit_vld) win_q <= win_nxt;
   end
endmodule

// File: rtl/cg_sof_hunt.sv
module cg_sof_hunt
   import cg_dec_pkg::*;
#(
   parameter int PRE_IDLES = 1,
   localparam int W = GROUP_W * (PRE_IDLES + 2)
) (
   input  logic [W-1:0] win,
   output logic         hit
);
   logic [PRE_IDLES-1:0] idle_ok;

   for (genvar g = 0; g < PRE_IDLES; g++) begin : g_prefix
      assign idle_ok[g] = (win[2*GROUP_W + g*GROUP_W +: GROUP_W] == CG_IDLE);
   end

   assign hit = (win[GROUP_W +: GROUP_W] == CG_J) &&
                (win[0 +: GROUP_W] == CG_K) && (&idle_ok);
endmodule

// File: rtl/cg_group_lut.sv
module cg_group_lut
   import cg_dec_pkg::*;
(
   input  logic [GROUP_W-1:0] cg,
   output logic               is_data,
   output logic               is_ctrl,
   output logic [NIB_W-1:0]   nib
);
   lut_out_t lo;

   always_comb begin
      lo      = cg_lookup(cg);
      is_data = lo.is_data;
      nib     = lo.nib;
      is_ctrl = (cg == CG_T) || (cg == CG_R) || (cg == CG_IDLE);
   end
endmodule

// File: rtl/cg_rx_decoder.sv
module cg_rx_decoder
   import cg_dec_pkg::*;
#(
   parameter int          PRE_IDLES = 1,
   parameter logic [3:0]  ERR_NIB   = 4'b1110
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_in,
   input  logic       bit_vld,
   output logic       rx_dv,
   output logic [3:0] rx_nib,
   output logic       rx_err,
   output logic       nib_stb
);
   localparam int WIN_W = GROUP_W * (PRE_IDLES + 2);
   localparam int CNT_W = $clog2(GROUP_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GROUP_W - 1);

   if (PRE_IDLES < 1 || PRE_IDLES > 4) begin : g_bad_pre
      $error("PRE_IDLES must lie in 1..4");
   end

   logic [WIN_W-1:0]   win_nxt;
   logic               sof_hit;
   logic [GROUP_W-1:0] cur_cg, prev_cg;
   logic               lut_data, lut_ctrl;
   logic [NIB_W-1:0]   lut_nib;

   dec_state_t         state;
   logic [CNT_W-1:0]   slot;
   logic               pre_pend;
   logic               grp_done, end_pair;

   cg_bit_window #(.W(WIN_W)) u_win (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .win_nxt(win_nxt)
   );

   cg_sof_hunt #(.PRE_IDLES(PRE_IDLES)) u_hunt (
      .win(win_nxt), .hit(sof_hit)
   );

   assign cur_cg  = win_nxt[0 +: GROUP_W];
   assign prev_cg = win_nxt[GROUP_W +: GROUP_W];

   cg_group_lut u_lut (
      .cg(cur_cg), .is_data(lut_data), .is_ctrl(lut_ctrl), .nib(lut_nib)
   );

   assign grp_done = (state == ST_FRAME) && bit_vld && (slot == CNT_LAST);
   assign end_pair = ((prev_cg == CG_T)    && (cur_cg == CG_R)) ||
                     ((prev_cg == CG_IDLE) && (cur_cg == CG_IDLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_HUNT;
         slot     <= '0;
         pre_pend <= 1'b0;
         rx_dv    <= 1'b0;
         rx_nib   <= '0;
         rx_err   <= 1'b0;
         nib_stb  <= 1'b0;
      end else begin
         nib_stb <= 1'b0;
         rx_err  <= 1'b0;
         unique case (state)
            ST_HUNT: begin
               if (bit_vld && sof_hit) begin
                  state    <= ST_FRAME;
                  slot     <= '0;
                  pre_pend <= 1'b1;
                  rx_dv    <= 1'b1;
                  rx_nib   <= NIB_PRE;
                  nib_stb  <= 1'b1;
               end
            end
            ST_FRAME: begin
               if (pre_pend) begin
                  pre_pend <= 1'b0;
                  rx_nib   <= NIB_PRE;
                  nib_stb  <= 1'b1;
               end
               if (bit_vld) slot <= (slot == CNT_LAST) ? '0 : slot + 1'b1;
               if (grp_done) begin
                  if (end_pair) begin
                     state  <= ST_HUNT;
                     rx_dv  <= 1'b0;
                     rx_nib <= '0;
                  end else if (lut_data) begin
                     rx_nib  <= lut_nib;
                     nib_stb <= 1'b1;
                  end else if (!lut_ctrl) begin
                     rx_nib  <= ERR_NIB;
                     rx_err  <= 1'b1;
                     nib_stb <= 1'b1;
                  end
               end
            end
            default: state <= ST_HUNT;
         endcase
      end
   end
endmodule

// File: rtl/cg_rx_decoder_chk.sv
module cg_rx_decoder_chk #(
   parameter logic [3:0] ERR_NIB = 4'b1110
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bit_vld,
   input logic       rx_dv,
   input logic [3:0] rx_nib,
   input logic       rx_err,
   input logic       nib_stb
);
   // R11
   stb_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nib_stb |-> rx_dv);

   // R3
   pre_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv) |-> (nib_stb && rx_nib == 4'b0101));

   // R3
   pre_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv) |=> (nib_stb && rx_nib == 4'b0101 && !rx_err));

   // R7
   err_marks_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> (nib_stb && rx_nib == ERR_NIB));

   // R8
   stb_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_stb && !$past(nib_stb)) |-> $past(bit_vld));

   // R5
   end_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_dv) |-> ($past(bit_vld) && !nib_stb));
endmodule

bind cg_rx_decoder cg_rx_decoder_chk #(.ERR_NIB(ERR_NIB)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_dv(rx_dv),
   .rx_nib(rx_nib), .rx_err(rx_err), .nib_stb(nib_stb)
);

// File: tb/cg_rx_decoder_bench.sv
module cg_rx_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_in = 1'b0;
   logic       bit_vld = 1'b0;
   logic       rx_dv, rx_err, nib_stb;
   logic [3:0] rx_nib;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cg_rx_decoder u_cg_rx_decoder (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
      .rx_dv(rx_dv), .rx_nib(rx_nib), .rx_err(rx_err), .nib_stb(nib_stb)
   );

   localparam logic [4:0] IDL = 5'b11111, J = 5'b11000, K = 5'b10001;
   localparam logic [4:0] T = 5'b01101, R = 5'b00111, BADC = 5'b00000;

   // {code-group, nibble}, R4
   localparam logic [8:0] VEC [16] = '{
      {5'b11110, 4'h0}, {5'b01001, 4'h1}, {5'b10100, 4'h2}, {5'b10101, 4'h3},
      {5'b01010, 4'h4}, {5'b01011, 4'h5}, {5'b01110, 4'h6}, {5'b01111, 4'h7},
      {5'b10010, 4'h8}, {5'b10011, 4'h9}, {5'b10110, 4'hA}, {5'b10111, 4'hB},
      {5'b11010, 4'hC}, {5'b11011, 4'hD}, {5'b11100, 4'hE}, {5'b11101, 4'hF}};

   logic [4:0] cap_q [$];
   logic [4:0] exp_q [$];
   bit         dv_low_at_stb = 0;

   always @(negedge clk) begin
      if (rst_n && nib_stb) begin
         cap_q.push_back({rx_err, rx_nib});
         if (!rx_dv) dv_low_at_stb = 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, input int gap);
      @(negedge clk);
      bit_in  = b;
      bit_vld = 1'b1;
      for (int i = 0; i < gap; i++) begin
         @(negedge clk);
         bit_vld = 1'b0;
         bit_in  = ~b;
      end
   endtask

   task automatic send_cg(input logic [4:0] c, input int gap);
      for (int i = 4; i >= 0; i--) send_bit(c[i], gap);
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_vld = 1'b0;
      end
   endtask

   task automatic compare(input string req);
      chk(cap_q.size() == exp_q.size(), req, cap_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
         chk(cap_q[i] == exp_q[i], req, cap_q[i], exp_q[i]);
      cap_q.delete();
      exp_q.delete();
   endtask

   task automatic exp_pre();
      exp_q.push_back(5'h05);
      exp_q.push_back(5'h05);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(rx_dv == 0 && nib_stb == 0 && rx_err == 0 && rx_nib == 0, "R9 reset",
          {rx_dv, nib_stb, rx_err, rx_nib}, 0);
      rst_n = 1'b1;
      quiet(2);

      // R3 R4 R5: full table walk in one frame
      send_cg(IDL, 0); send_cg(IDL, 0); send_cg(J, 0); send_cg(K, 0);
      exp_pre();
      for (int v = 0; v < 16; v++) begin
         send_cg(VEC[v][8:4], 0);
         exp_q.push_back({1'b0, VEC[v][3:0]});
      end
      send_cg(T, 0);
      chk(rx_dv == 1, "R5 dv held across T", rx_dv, 1);
      send_cg(R, 0);
      quiet(2);
      chk(rx_dv == 0, "R5 dv drops after T/R", rx_dv, 0);
      compare("R4 table decode");

      // R10 R1 R6: odd bit phase, end on two idles
      send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
      send_cg(IDL, 0); send_cg(IDL, 0); send_cg(J, 0); send_cg(K, 0);
      send_cg(5'b01111, 0); send_cg(5'b11010, 0);
      send_cg(IDL, 0); send_cg(IDL, 0);
      quiet(2);
      exp_pre(); exp_q.push_back(5'h07); exp_q.push_back(5'h0C);
      chk(rx_dv == 0, "R6 dv drops after two idles", rx_dv, 0);
      compare("R1 R10 realign");

      // R2: J/K without IDLE prefix ignored
      send_cg(5'b00000, 0); send_cg(5'b10100, 0); send_cg(J, 0); send_cg(K, 0);
      send_cg(5'b01011, 0); send_cg(5'b01001, 0);
      quiet(2);
      chk(rx_dv == 0, "R2 no frame start", rx_dv, 0);
      compare("R2 no strobes");

      // R7 R6 R5: invalid code, lone IDLE, lone T
      send_cg(IDL, 0); send_cg(J, 0); send_cg(K, 0);
      send_cg(5'b01001, 0); send_cg(BADC, 0); send_cg(IDL, 0);
      send_cg(5'b10100, 0); send_cg(T, 0); send_cg(5'b10101, 0);
      send_cg(T, 0); send_cg(R, 0);
      quiet(2);
      exp_pre(); exp_q.push_back(5'h01); exp_q.push_back(5'h1E);
      exp_q.push_back(5'h02); exp_q.push_back(5'h03);
      chk(rx_dv == 0, "R5 end after lone T", rx_dv, 0);
      compare("R7 error nibble and continue");

      // R8: gaps between valid bits
      send_cg(IDL, 2); send_cg(J, 1); send_cg(K, 3);
      send_cg(5'b10011, 2); send_cg(5'b10110, 1);
      send_cg(T, 1); send_cg(R, 2);
      quiet(2);
      exp_pre(); exp_q.push_back(5'h09); exp_q.push_back(5'h0A);
      chk(rx_dv == 0, "R8 frame closed", rx_dv, 0);
      compare("R8 gapped bits");

      // R11
      chk(dv_low_at_stb == 0, "R11 strobe outside frame", dv_low_at_stb, 0);

      // R9: reset in mid-frame
      send_cg(IDL, 0); send_cg(J, 0); send_cg(K, 0); send_cg(5'b11100, 0);
      quiet(1);
      chk(rx_dv == 1, "R9 frame open before reset", rx_dv, 1);
      rst_n = 1'b0;
      quiet(1);
      chk(rx_dv == 0 && nib_stb == 0 && rx_nib == 0, "R9 mid-frame reset",
          {rx_dv, nib_stb, rx_nib}, 0);
      cap_q.delete();
      rst_n = 1'b1;
      quiet(2);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule